// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

The block drives four independent pulse-width modulated outputs from one input clock. Software programs it through a small word-addressed register window. One shared control word holds a run bit for every channel and a 2-bit step-rate code for every channel. A separate configuration word for each channel holds the period length and the high time, both counted in steps. The step-rate code sets the length of one step to 1, 8, 64 or 512 input clocks. The faster rates tap a cascade of divide-by-8 stages.

A running channel counts steps from zero up to its period length minus one. Its output is high while the count is below the high time. A new period length or high time does not act as soon as it is written. The channel loads it when it wraps to the start of the next period, so no cut or stretched period ever reaches the pin. A stopped channel holds its step counter and its divider at zero and drives its output low. Setting the run bit again therefore starts a full, clean period at once.

Top module: `stepped_pwm_bank`

## Requirements
- R1: The control word is word address 0. Bits [3:0] are the run bits of channels 0..3. Channel n's step-rate code sits in bits [2n+5:2n+4]. All other bits read as 0. Channel n's configuration word is word address 1+n, with the period length in bits [15:0] and the high time in bits [31:16]. It reads back exactly as written. Writes to word addresses 5..7 are ignored, and those addresses read 0.
- R2: While a channel runs with step-rate code 0, a nonzero period length P and a high time D with 0 < D < P, its output is high for D clocks and then low for P-D clocks. This repeats, starting with the first clock after the run bit is written.
- R3: Step-rate codes 0, 1, 2 and 3 make one step last 1, 8, 64 and 512 input clocks, so every high and low interval scales by that factor.
- R4: A high time of 0 keeps a running channel's output low. A high time greater than or equal to the period length keeps it high.
- R5: A period length of 0 keeps the output low whatever the high time.
- R6: A channel whose run bit is 0 drives its output low from the clock after the bit is cleared. Setting the bit again restarts the channel at the first step of a fresh period.
- R7: A configuration word written while the channel runs takes effect only at the start of the next period. The period in progress completes with its old values.
- R8: Channels are independent. A channel's output depends only on its own run bit, step-rate code and configuration word, and channels whose run bit is 0 stay low while others run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; steps are derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 3 | Word address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the word at `addr` (combinational) |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
A wrong divider or step counter shows at the pins within one period. An edge arrives one step early or late, and with step-rate code 0 that means a single input clock, so the bench compares every output on every clock against a pattern computed from the enable time. A bad active-value register shows up as a wrong high time in the period just after the boundary where it loads. A load at the wrong moment shows up as a cut period right after a write made mid-period. State that fails to clear when a channel stops shows up as a shifted pattern in the first step after the channel is enabled again. The sweep enables channels again many times to expose that.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  // Word map of the register window
  localparam int unsigned CTRL_WORD     = 0;
  localparam int unsigned CFG_WORD_BASE = 1;
  // Step-rate code field placement inside the control word
  localparam int unsigned SEL_LSB       = 4;
  localparam int unsigned SEL_W         = 2;
  // Each divider stage divides by 2**DIV_STAGE_LOG
  localparam int unsigned DIV_STAGE_LOG = 3;

  typedef enum logic [SEL_W-1:0] {
    RATE_DIV1   = 2'd0,
    RATE_DIV8   = 2'd1,
    RATE_DIV64  = 2'd2,
    RATE_DIV512 = 2'd3
  } step_rate_e;
endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
  import spwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [2*CNT_W-1:0]               wr_data,
  output logic [2*CNT_W-1:0]               rd_data,
  output logic [NUM_CH-1:0]                run_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]     rate_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]     period_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]     high_o
);
  localparam int DATA_W = 2 * CNT_W;

  logic                         ctrl_we;
  logic [NUM_CH-1:0]            cfg_we;
  logic [NUM_CH-1:0]            run_q, run_d;
  logic [NUM_CH-1:0][SEL_W-1:0] rate_q, rate_d;
  logic [NUM_CH-1:0][DATA_W-1:0] cfg_q;

  // Write decode and next-state values
  always_comb begin
    ctrl_we = wr_en && (addr == ADDR_W'(CTRL_WORD));
    run_d   = wr_data[NUM_CH-1:0];
    for (int n = 0; n < NUM_CH; n++) begin
      cfg_we[n] = wr_en && (addr == ADDR_W'(CFG_WORD_BASE + n));
      rate_d[n] = wr_data[SEL_LSB + SEL_W*n +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      rate_q <= '0;
    end else if (ctrl_we) begin
      run_q  <= run_d;
      rate_q <= rate_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (cfg_we[g]) begin
        cfg_q[g] <= wr_data;
      end
    end
    assign period_o[g] = cfg_q[g][CNT_W-1:0];
    assign high_o[g]   = cfg_q[g][DATA_W-1:CNT_W];
  end

  // Read mux: unused control bits and unmapped words return zero
  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(CTRL_WORD)) begin
      rd_data[NUM_CH-1:0] = run_q;
      for (int n = 0; n < NUM_CH; n++) begin
        rd_data[SEL_LSB + SEL_W*n +: SEL_W] = rate_q[n];
      end
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (addr == ADDR_W'(CFG_WORD_BASE + n)) begin
          rd_data = cfg_q[n];
        end
      end
    end
  end

  assign run_o  = run_q;
  assign rate_o = rate_q;
endmodule

// File: rtl/spwm_prescaler.sv
module spwm_prescaler
  import spwm_pkg::*;
#(
  parameter int STAGE_LOG = DIV_STAGE_LOG,
  parameter int RATE_W    = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              step_o
);
  localparam int NUM_RATES = 1 << RATE_W;
  localparam int PRE_W     = STAGE_LOG * (NUM_RATES - 1);

  logic [PRE_W-1:0]                 pre_q, pre_d;
  logic [NUM_RATES-1:0][PRE_W-1:0]  tap_mask;

  // Rate code c taps the low STAGE_LOG*c bits of the cascade
  for (genvar c = 0; c < NUM_RATES; c++) begin : g_tap
    localparam logic [PRE_W-1:0] MASK = {PRE_W{1'b1}} >> (PRE_W - STAGE_LOG*c);
    assign tap_mask[c] = MASK;
  end

  always_comb begin
    pre_d  = run ? pre_q + 1'b1 : '0;
    step_o = run && (&(pre_q | ~tap_mask[rate]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/spwm_channel.sv
module spwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_high,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_period_o,
  output logic [CNT_W-1:0] act_high_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, high_q;
  logic             idle_per, at_end, wrap, load;

  always_comb begin
    idle_per = (per_q == '0);
    at_end   = (cnt_q == per_q - 1'b1);
    wrap     = step && (at_end || idle_per);
    // Stopped channels track the programmed values; running ones pick
    // them up only at a period boundary.
    load     = !run || wrap;
    if (!run || wrap) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      high_q <= '0;
    end else if (load) begin
      per_q  <= cfg_period;
      high_q <= cfg_high;
    end
  end

  assign pwm_o        = run && !idle_per && (cnt_q < high_q);
  assign cnt_o        = cnt_q;
  assign act_period_o = per_q;
  assign act_high_o   = high_q;
endmodule

// File: rtl/stepped_pwm_bank.sv
module stepped_pwm_bank
  import spwm_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int CNT_W  = 16,
  parameter  int ADDR_W = 3,
  localparam int DATA_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]            ch_en;
  logic [NUM_CH-1:0][SEL_W-1:0] ch_rate;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_period, ch_high;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt, ch_act_period, ch_act_high;
  logic [NUM_CH-1:0]            ch_step;

  spwm_regs #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .run_o    (ch_en),
    .rate_o   (ch_rate),
    .period_o (ch_period),
    .high_o   (ch_high)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    spwm_prescaler #(
      .STAGE_LOG (DIV_STAGE_LOG),
      .RATE_W    (SEL_W)
    ) i_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ch_en[g]),
      .rate   (ch_rate[g]),
      .step_o (ch_step[g])
    );

    spwm_channel #(
      .CNT_W (CNT_W)
    ) i_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (ch_en[g]),
      .step         (ch_step[g]),
      .cfg_period   (ch_period[g]),
      .cfg_high     (ch_high[g]),
      .pwm_o        (pwm_out[g]),
      .cnt_o        (ch_cnt[g]),
      .act_period_o (ch_act_period[g]),
      .act_high_o   (ch_act_high[g])
    );
  end
endmodule

// File: rtl/spwm_checker.sv
module spwm_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CH-1:0]              en,
  input logic [NUM_CH-1:0]              pwm,
  input logic [NUM_CH-1:0][CNT_W-1:0]   cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0]   act_period,
  input logic [NUM_CH-1:0][CNT_W-1:0]   act_high
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_OFF_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) !en[g] |-> !pwm[g]); // R6
    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ($rose(en[g]) && act_period[g] != '0 && act_high[g] != '0) |-> pwm[g]); // R6
    AST_IDLE_PERIOD_LOW: assert property (@(posedge clk) disable iff (!rst_n) (act_period[g] == '0) |-> !pwm[g]); // R5
    AST_ZERO_HIGH_LOW: assert property (@(posedge clk) disable iff (!rst_n) (act_high[g] == '0) |-> !pwm[g]); // R4
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (en[g] && act_period[g] != '0 && act_high[g] >= act_period[g]) |-> pwm[g]); // R4
    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) (act_period[g] != '0) |-> (cnt[g] < act_period[g])); // R2
    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n) (en[g] && $past(en[g]) && cnt[g] != '0) |-> ($stable(act_period[g]) && $stable(act_high[g]))); // R7
  end
endmodule

bind stepped_pwm_bank spwm_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) i_spwm_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (ch_en),
  .pwm        (pwm_out),
  .cnt        (ch_cnt),
  .act_period (ch_act_period),
  .act_high   (ch_act_high)
);

// File: tb/test_stepped_pwm_bank.sv
module test_stepped_pwm_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  pwm_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepped_pwm_bank i_stepped_pwm_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pwm_out (pwm_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a negedge, captured at the next posedge, returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr    = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  // Expected level k clocks after the enable edge
  function automatic logic exp_level(int k, int code, int per, int high);
    int div;
    div = 1 << (3 * code);
    if (per == 0) return 1'b0;
    return ((k / div) % per) < high;
  endfunction

  task automatic run_pat(input int ch, input int code, input int per, input int high, input int ncyc);
    string tag;
    logic [3:0] mask;
    mask = 4'(1 << ch);
    if (per == 0)                      tag = "R5";
    else if (high == 0 || high >= per) tag = "R4";
    else if (code != 0)                tag = "R3";
    else                               tag = "R2";
    wr(3'(1 + ch), {high[15:0], per[15:0]});
    wr(3'd0, 32'(mask) | 32'(code << (2*ch + 4)));
    for (int k = 0; k < ncyc; k++) begin
      check(tag, 32'(pwm_out[ch]), 32'(exp_level(k, code, per, high)));
      check("R8 others low", 32'(pwm_out & ~mask), 32'h0);
      @(negedge clk);
    end
    wr(3'd0, 32'h0);
    check("R6 stop", 32'(pwm_out), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    addr    = '0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rdchk(3'd0, 32'h0, "R1 reset ctrl");
    check("R6 reset outputs", 32'(pwm_out), 32'h0);

    // Register map and readback
    wr(3'd0, 32'hFFFF_F0F0);
    rdchk(3'd0, 32'h0000_00F0, "R1 ctrl unused bits");
    check("R6 no run bits", 32'(pwm_out), 32'h0);
    wr(3'd3, 32'hDEAD_BEEF);
    rdchk(3'd3, 32'hDEAD_BEEF, "R1 cfg readback");
    wr(3'd6, 32'h1234_5678);
    rdchk(3'd6, 32'h0, "R1 unmapped word");
    rdchk(3'd1, 32'h0, "R1 unmapped write ignored");
    rdchk(3'd3, 32'hDEAD_BEEF, "R1 cfg kept");
    wr(3'd0, 32'h0000_0E31);
    rdchk(3'd0, 32'h0000_0E31, "R1 ctrl readback");
    check("R5 zero period with run", 32'(pwm_out), 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h0);

    // Rate code 0: every period and high time, channels rotated
    for (int per = 1; per <= 5; per++)
      for (int high = 0; high <= per + 1; high++)
        run_pat((per + high) % NUM_CH, 0, per, high, 3 * per + 2);
    run_pat(2, 0, 3, 16'hFFFF, 10);
    run_pat(1, 0, 0, 5, 10);
    run_pat(3, 1, 0, 2, 20);

    // Rate code 1
    for (int per = 1; per <= 3; per++)
      for (int high = 0; high <= per + 1; high++)
        run_pat((per + high + 1) % NUM_CH, 1, per, high, 2 * per * 8 + 3);

    // Rate code 2
    for (int high = 0; high <= 3; high++)
      run_pat(high % NUM_CH, 2, 2, high, 2 * 2 * 64 + 3);

    // Rate code 3
    run_pat(3, 3, 2, 1, 2 * 2 * 512 + 3);

    // R7: mid-period rewrite waits for the boundary
    wr(3'd1, {16'd1, 16'd4});
    wr(3'd0, 32'h1);
    check("R7 k0", 32'(pwm_out[0]), 32'h1);
    @(negedge clk);
    check("R7 k1", 32'(pwm_out[0]), 32'h0);
    wr(3'd1, {16'd2, 16'd2});
    check("R7 old period k2", 32'(pwm_out[0]), 32'h0);
    @(negedge clk);
    check("R7 old period k3", 32'(pwm_out[0]), 32'h0);
    @(negedge clk);
    for (int k = 4; k < 8; k++) begin
      check("R7 new values", 32'(pwm_out[0]), 32'h1);
      @(negedge clk);
    end
    wr(3'd0, 32'h0);
    check("R6 stop after R7", 32'(pwm_out), 32'h0);

    // R8: two channels at once with different settings
    wr(3'd1, {16'd1, 16'd2});
    wr(3'd4, {16'd2, 16'd3});
    wr(3'd0, 32'h9 | 32'(1 << (2*3 + 4)));
    for (int k = 0; k < 48; k++) begin
      check("R8 ch0", 32'(pwm_out[0]), 32'(exp_level(k, 0, 2, 1)));
      check("R8 ch3", 32'(pwm_out[3]), 32'(exp_level(k, 1, 3, 2)));
      check("R8 idle ch1 ch2", 32'(pwm_out[2:1]), 32'h0);
      @(negedge clk);
    end
    wr(3'd0, 32'h0);
    check("R6 final stop", 32'(pwm_out), 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule